// File: doc/BRIEF.md
# Single-Cycle Load/Store Processor Core

This block is a 32-bit processor core that fetches, decodes and completes one instruction on every rising clock edge. It implements a small integer subset: register-to-register add, subtract, bitwise and, bitwise or and signed set-less-than, plus word load, word store, branch-if-equal and an absolute jump. The core holds a program counter, a 32-entry general register file, a sign extender, an ALU, a two-level decoder and two separate word-addressed memories, one for instructions and one for data.

Decoding is split into two levels. The opcode produces the datapath steering bits and a 2-bit ALU class. For register-to-register instructions, the function field then refines that class into a 4-bit ALU operation. Both memories are internal arrays. A testbench or system loader fills them hierarchically while reset is held. The only outputs are debug observation ports: the current program counter and a registered record of each register-file write.

Top module: `sc_core`

## Requirements
- R1: While `rst` is high at a rising edge, the PC becomes 0 and no register write or data-memory write takes place. After that edge `dbg_pc` is 0 and `dbg_wr_en` is 0.
- R2: An instruction word is read from instruction-memory index PC[IMEM_AW+1:2] with no read enable. When the instruction is neither a taken branch nor a jump, the next PC is PC+4.
- R3: Field positions are fixed: opcode [31:26], rs [25:21], rt [20:16], rd [15:11], funct [5:0], immediate [15:0] and jump field [25:0]. Opcode 000000 is register-to-register and writes rd with rs op rt. The funct codes are 100000 add, 100010 subtract, 100100 and, and 100101 or. Add and subtract wrap modulo 2^32.
- R4: Funct 101010 (set-less-than) writes 1 to rd when rs is below rt as a signed two's-complement value, and writes 0 otherwise.
- R5: Opcode 100011 (load) writes rt with the data word at byte address rs + sign-extended immediate. The word index is address bits [DMEM_AW+1:2].
- R6: Opcode 101011 (store) writes the value of rt to the data word at rs + sign-extended immediate. It performs no register write.
- R7: Opcode 000100 (branch-if-equal) subtracts rt from rs. When the result is zero, the next PC is PC+4 + (sign-extended immediate << 2); otherwise it is PC+4. It performs no register write.
- R8: Opcode 000010 (jump) sets the next PC to {(PC+4)[31:28], jump field, 2'b00}. It performs no register write.
- R9: Register 0 always reads as zero. A write aimed at register 0 is discarded and produces no write record on the debug port.
- R10: After each edge that commits a register write, `dbg_wr_en` is 1 and `dbg_wr_addr`/`dbg_wr_data` carry that write until the next edge. `dbg_pc` always shows the PC of the instruction about to execute.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| dbg_pc | output | 32 | Current program counter |
| dbg_wr_en | output | 1 | A register write was committed at the last edge |
| dbg_wr_addr | output | 5 | Register number of that write |
| dbg_wr_data | output | 32 | Value written |

## Verification
Every architectural state element leaves a mark on the ports by the next edge. A wrong PC shows up at once on `dbg_pc`. A wrong register value appears on the write record of the first instruction that consumes it. A corrupted data word appears when a later load brings it back to the write port. Each program run is arranged so that every written register and memory word is consumed within a few instructions. The bench also places sentinel instructions in the shadow of each branch and jump, so a wrong redirection produces either a foreign PC or an unexpected write record in the very next cycle.

// File: rtl/sc_core_pkg.sv
package sc_core_pkg;

  typedef enum logic [3:0] {
    ALU_AND = 4'b0000,
    ALU_OR  = 4'b0001,
    ALU_ADD = 4'b0010,
    ALU_SUB = 4'b0110,
    ALU_SLT = 4'b0111
  } alu_op_e;

  typedef enum logic [1:0] {
    CLS_MEM = 2'b00,
    CLS_BR  = 2'b01,
    CLS_FN  = 2'b10
  } alu_cls_e;

  localparam logic [5:0] OPC_RTYPE = 6'b000000;
  localparam logic [5:0] OPC_LOAD  = 6'b100011;
  localparam logic [5:0] OPC_STORE = 6'b101011;
  localparam logic [5:0] OPC_BEQ   = 6'b000100;
  localparam logic [5:0] OPC_JUMP  = 6'b000010;

  localparam logic [5:0] FN_ADD = 6'b100000;
  localparam logic [5:0] FN_SUB = 6'b100010;
  localparam logic [5:0] FN_AND = 6'b100100;
  localparam logic [5:0] FN_OR  = 6'b100101;
  localparam logic [5:0] FN_SLT = 6'b101010;

  typedef struct packed {
    logic     dst_rd;
    logic     b_imm;
    logic     wb_mem;
    logic     reg_we;
    logic     mem_we;
    logic     branch;
    logic     jump;
    alu_cls_e cls;
  } ctrl_t;

endpackage

// File: rtl/sc_decode.sv
module sc_decode
  import sc_core_pkg::*;
(
  input  logic [5:0] opcode,
  input  logic [5:0] funct,
  output ctrl_t      ctrl,
  output alu_op_e    alu_op
);

  // first level: opcode -> steering and ALU class
  always_comb begin
    ctrl = '{dst_rd: 1'b0, b_imm: 1'b0, wb_mem: 1'b0, reg_we: 1'b0,
             mem_we: 1'b0, branch: 1'b0, jump: 1'b0, cls: CLS_MEM};
    case (opcode)
      OPC_RTYPE: begin
        ctrl.dst_rd = 1'b1;
        ctrl.reg_we = 1'b1;
        ctrl.cls    = CLS_FN;
      end
      OPC_LOAD: begin
        ctrl.b_imm  = 1'b1;
        ctrl.wb_mem = 1'b1;
        ctrl.reg_we = 1'b1;
      end
      OPC_STORE: begin
        ctrl.b_imm  = 1'b1;
        ctrl.mem_we = 1'b1;
      end
      OPC_BEQ: begin
        ctrl.branch = 1'b1;
        ctrl.cls    = CLS_BR;
      end
      OPC_JUMP: ctrl.jump = 1'b1;
      default: ;
    endcase
  end

  // second level: class refined by funct
  always_comb begin
    case (ctrl.cls)
      CLS_BR: alu_op = ALU_SUB;
      CLS_FN: begin
        case (funct)
          FN_SUB:  alu_op = ALU_SUB;
          FN_AND:  alu_op = ALU_AND;
          FN_OR:   alu_op = ALU_OR;
          FN_SLT:  alu_op = ALU_SLT;
          default: alu_op = ALU_ADD;
        endcase
      end
      default: alu_op = ALU_ADD;
    endcase
  end

endmodule

// File: rtl/sc_alu.sv
module sc_alu
  import sc_core_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  alu_op_e      op,
  output logic [W-1:0] y,
  output logic         zero
);

  logic [W-1:0] diff;
  assign diff = a - b;

  always_comb begin
    case (op)
      ALU_AND: y = a & b;
      ALU_OR:  y = a | b;
      ALU_SUB: y = diff;
      ALU_SLT: y = {{(W-1){1'b0}}, ($signed(a) < $signed(b))};
      default: y = a + b;
    endcase
  end

  assign zero = (y == '0);

endmodule

// File: rtl/sc_regfile.sv
module sc_regfile #(
  parameter int W     = 32,
  parameter int DEPTH = 32,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [W-1:0]  wd,
  input  logic [AW-1:0] ra1,
  input  logic [AW-1:0] ra2,
  output logic [W-1:0]  rd1,
  output logic [W-1:0]  rd2
);

  logic [W-1:0] regs [DEPTH];

  always_ff @(posedge clk) begin
    if (we && wa != '0) regs[wa] <= wd;
  end

  assign rd1 = (ra1 == '0) ? '0 : regs[ra1];
  assign rd2 = (ra2 == '0) ? '0 : regs[ra2];

endmodule

// File: rtl/sc_core.sv
module sc_core
  import sc_core_pkg::*;
#(
  parameter int XLEN    = 32,
  parameter int NREGS   = 32,
  parameter int IMEM_AW = 6,
  parameter int DMEM_AW = 6,
  localparam int RAW    = $clog2(NREGS)
) (
  input  logic            clk,
  input  logic            rst,
  output logic [XLEN-1:0] dbg_pc,
  output logic            dbg_wr_en,
  output logic [RAW-1:0]  dbg_wr_addr,
  output logic [XLEN-1:0] dbg_wr_data
);

  localparam int IMEM_WORDS = 1 << IMEM_AW;
  localparam int DMEM_WORDS = 1 << DMEM_AW;

  logic [31:0]     imem [IMEM_WORDS];
  logic [XLEN-1:0] dmem [DMEM_WORDS];

  initial begin
    for (int i = 0; i < IMEM_WORDS; i++) imem[i] = '0;
    for (int i = 0; i < DMEM_WORDS; i++) dmem[i] = '0;
  end

  logic [XLEN-1:0] pc_q, pc_next, pc_plus4, br_target, imm_ext;
  logic [31:0]     instr;
  ctrl_t           ctrl;
  alu_op_e         alu_op;
  logic [XLEN-1:0] rs_val, rt_val, alu_b, alu_y, ld_data, wb_data;
  logic            alu_zero, take_br, jump_sel, rf_we, dm_we;
  logic [RAW-1:0]  wr_addr;

  assign instr = imem[pc_q[IMEM_AW+1:2]];

  sc_decode u_dec (
    .opcode (instr[31:26]),
    .funct  (instr[5:0]),
    .ctrl   (ctrl),
    .alu_op (alu_op)
  );

  sc_regfile #(.W(XLEN), .DEPTH(NREGS)) u_rf (
    .clk (clk),
    .we  (rf_we),
    .wa  (wr_addr),
    .wd  (wb_data),
    .ra1 (instr[25:21]),
    .ra2 (instr[20:16]),
    .rd1 (rs_val),
    .rd2 (rt_val)
  );

  assign imm_ext = {{(XLEN-16){instr[15]}}, instr[15:0]};
  assign alu_b   = ctrl.b_imm ? imm_ext : rt_val;

  sc_alu #(.W(XLEN)) u_alu (
    .a    (rs_val),
    .b    (alu_b),
    .op   (alu_op),
    .y    (alu_y),
    .zero (alu_zero)
  );

  assign ld_data = dmem[alu_y[DMEM_AW+1:2]];
  assign wb_data = ctrl.wb_mem ? ld_data : alu_y;
  assign wr_addr = ctrl.dst_rd ? instr[15:11] : instr[20:16];
  assign rf_we   = ctrl.reg_we & ~rst;
  assign dm_we   = ctrl.mem_we & ~rst;

  always_ff @(posedge clk) begin
    if (dm_we) dmem[alu_y[DMEM_AW+1:2]] <= rt_val;
  end

  assign pc_plus4  = pc_q + XLEN'(4);
  assign br_target = pc_plus4 + {imm_ext[XLEN-3:0], 2'b00};
  assign take_br   = ctrl.branch & alu_zero;
  assign jump_sel  = ctrl.jump;

  always_comb begin
    if (jump_sel)     pc_next = {pc_plus4[XLEN-1:28], instr[25:0], 2'b00};
    else if (take_br) pc_next = br_target;
    else              pc_next = pc_plus4;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q        <= '0;
      dbg_wr_en   <= 1'b0;
      dbg_wr_addr <= '0;
      dbg_wr_data <= '0;
    end else begin
      pc_q        <= pc_next;
      dbg_wr_en   <= rf_we && (wr_addr != '0);
      dbg_wr_addr <= wr_addr;
      dbg_wr_data <= wb_data;
    end
  end

  assign dbg_pc = pc_q;

endmodule

// File: rtl/sc_core_chk.sv
module sc_core_chk
  import sc_core_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int RAW  = 5
) (
  input logic            clk,
  input logic            rst,
  input logic [XLEN-1:0] pc,
  input logic [31:0]     instr,
  input logic            take_br,
  input logic            jump_sel,
  input logic            rf_we,
  input alu_op_e         alu_op,
  input logic [XLEN-1:0] alu_y,
  input logic            dbg_wr_en,
  input logic [RAW-1:0]  dbg_wr_addr
);

  p_reset_pc_r1: assert property (@(posedge clk) rst |=> (pc == '0 && !dbg_wr_en));

  p_seq_pc_r2: assert property (@(posedge clk) disable iff (rst)
    (!take_br && !jump_sel) |=> pc == $past(pc) + XLEN'(4));

  p_slt_bit_r4: assert property (@(posedge clk) disable iff (rst)
    (alu_op == ALU_SLT) |-> (alu_y[XLEN-1:1] == '0));

  p_store_nowr_r6: assert property (@(posedge clk) disable iff (rst)
    (instr[31:26] == OPC_STORE || instr[31:26] == OPC_BEQ) |-> !rf_we);

  p_jump_tgt_r8: assert property (@(posedge clk) disable iff (rst)
    jump_sel |=> pc[27:0] == {$past(instr[25:0]), 2'b00});

  p_no_r0_r9: assert property (@(posedge clk) disable iff (rst)
    dbg_wr_en |-> dbg_wr_addr != '0);

endmodule

bind sc_core sc_core_chk #(.XLEN(XLEN), .RAW(RAW)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .pc          (pc_q),
  .instr       (instr),
  .take_br     (take_br),
  .jump_sel    (jump_sel),
  .rf_we       (rf_we),
  .alu_op      (alu_op),
  .alu_y       (alu_y),
  .dbg_wr_en   (dbg_wr_en),
  .dbg_wr_addr (dbg_wr_addr)
);

// File: tb/sim_sc_core.sv
`timescale 1ns/1ps
module sim_sc_core;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] dbg_pc;
  logic        dbg_wr_en;
  logic [4:0]  dbg_wr_addr;
  logic [31:0] dbg_wr_data;

  int n_checks = 0;
  int n_fail   = 0;

  always #5 clk = ~clk;

  sc_core u0 (
    .clk(clk), .rst(rst), .dbg_pc(dbg_pc), .dbg_wr_en(dbg_wr_en),
    .dbg_wr_addr(dbg_wr_addr), .dbg_wr_data(dbg_wr_data)
  );

  function automatic logic [31:0] rtype(input int rs, input int rt, input int rd, input logic [5:0] fn);
    return {6'b000000, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
  endfunction

  function automatic logic [31:0] itype(input logic [5:0] op, input int rs, input int rt, input int imm);
    return {op, 5'(rs), 5'(rt), 16'(imm)};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  task automatic load_program(input logic [31:0] a, input logic [31:0] b);
    logic [31:0] sentinel;
    sentinel = rtype(1, 1, 15, 6'b100000);
    for (int i = 0; i < 64; i++) u0.imem[i] = sentinel;
    u0.imem[0]  = itype(6'b100011, 0, 1, 0);     // lw r1,0(r0)
    u0.imem[1]  = itype(6'b100011, 0, 2, 4);     // lw r2,4(r0)
    u0.imem[2]  = rtype(1, 2, 3, 6'b100000);     // add
    u0.imem[3]  = rtype(1, 2, 4, 6'b100010);     // sub
    u0.imem[4]  = rtype(1, 2, 5, 6'b100100);     // and
    u0.imem[5]  = rtype(1, 2, 6, 6'b100101);     // or
    u0.imem[6]  = rtype(1, 2, 7, 6'b101010);     // slt r7,r1,r2
    u0.imem[7]  = rtype(2, 1, 8, 6'b101010);     // slt r8,r2,r1
    u0.imem[8]  = rtype(1, 2, 0, 6'b100000);     // add r0 (discarded)
    u0.imem[9]  = rtype(0, 1, 9, 6'b100000);     // add r9,r0,r1
    u0.imem[10] = itype(6'b101011, 0, 3, 8);     // sw r3,8(r0)
    u0.imem[11] = itype(6'b100011, 0, 10, 8);    // lw r10,8(r0)
    u0.imem[12] = itype(6'b000100, 1, 2, 5);     // beq r1,r2 (not taken)
    u0.imem[13] = itype(6'b000100, 1, 1, 2);     // beq r1,r1 -> 64
    u0.imem[16] = {6'b000010, 26'd20};           // j 80
    u0.imem[20] = itype(6'b100011, 0, 14, 12);   // lw r14,12(r0)
    u0.imem[21] = itype(6'b100011, 14, 13, -4);  // lw r13,-4(r14)
    u0.imem[22] = itype(6'b000100, 0, 0, -1);    // beq r0,r0 -> self
    for (int i = 0; i < 64; i++) u0.dmem[i] = 32'h0;
    u0.dmem[0] = a;
    u0.dmem[1] = b;
    u0.dmem[3] = 32'd12;
  endtask

  task automatic run_pair(input logic [31:0] a, input logic [31:0] b);
    int          epc [1:20];
    bit          een [1:20];
    int          ead [1:20];
    logic [31:0] edt [1:20];
    string       tg  [1:20];
    int pcs [20] = '{4,8,12,16,20,24,28,32,36,40,44,48,52,64,80,84,88,88,88,88};
    for (int k = 1; k <= 20; k++) begin
      epc[k] = pcs[k-1]; een[k] = 0; ead[k] = 0; edt[k] = 0; tg[k] = "R2";
    end
    een[1]=1; ead[1]=1;  edt[1]=a;      tg[1]="R5";
    een[2]=1; ead[2]=2;  edt[2]=b;      tg[2]="R5";
    een[3]=1; ead[3]=3;  edt[3]=a+b;    tg[3]="R3";
    een[4]=1; ead[4]=4;  edt[4]=a-b;    tg[4]="R3";
    een[5]=1; ead[5]=5;  edt[5]=a&b;    tg[5]="R3";
    een[6]=1; ead[6]=6;  edt[6]=a|b;    tg[6]="R3";
    een[7]=1; ead[7]=7;  edt[7]=($signed(a) < $signed(b)) ? 1 : 0; tg[7]="R4";
    een[8]=1; ead[8]=8;  edt[8]=($signed(b) < $signed(a)) ? 1 : 0; tg[8]="R4";
    tg[9]="R9";
    een[10]=1; ead[10]=9;  edt[10]=a;   tg[10]="R9";
    tg[11]="R6";
    een[12]=1; ead[12]=10; edt[12]=a+b; tg[12]="R6";
    tg[13]="R7"; tg[14]="R7"; tg[15]="R8";
    een[16]=1; ead[16]=14; edt[16]=12;  tg[16]="R5";
    een[17]=1; ead[17]=13; edt[17]=a+b; tg[17]="R5";
    tg[18]="R7"; tg[19]="R7"; tg[20]="R7";

    rst = 1'b1;
    load_program(a, b);
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    chk(dbg_pc == 0, "R1 pc under reset", dbg_pc, 0);
    chk(dbg_wr_en == 0, "R1 write record under reset", 32'(dbg_wr_en), 0);
    rst = 1'b0;
    for (int k = 1; k <= 20; k++) begin
      @(posedge clk);
      @(negedge clk);
      chk(dbg_pc == 32'(epc[k]), {tg[k], " R10 pc step"}, dbg_pc, 32'(epc[k]));
      chk(dbg_wr_en == een[k], {tg[k], " R10 write enable"}, 32'(dbg_wr_en), 32'(een[k]));
      if (een[k] && dbg_wr_en) begin
        chk(dbg_wr_addr == 5'(ead[k]), {tg[k], " write addr"}, 32'(dbg_wr_addr), 32'(ead[k]));
        chk(dbg_wr_data == edt[k], {tg[k], " write data"}, dbg_wr_data, edt[k]);
      end
    end
  endtask

  initial begin
    #1;
    run_pair(32'd5, 32'd3);
    run_pair(32'd3, 32'd5);
    run_pair(-32'sd7, 32'd2);
    run_pair(32'h7fffffff, 32'd1);
    run_pair(32'h80000000, 32'd1);
    run_pair(32'hffffffff, 32'hfffffffe);
    run_pair(32'h0f0f00ff, 32'hf0f0ff00);
    summary();
  end

  initial begin
    #2000000;
    n_checks++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    summary();
  end

endmodule